// File: doc/BRIEF.md
# Programmable Serial Bit-Clock Generator

This block derives the bit clock of a synchronous serial port from a fast oscillator clock. It chains three dividers. The first is a fixed divide-by-four stage. The second is a divide-by-eight prescaler that the range input switches in or out. The third is a programmable divider whose 8-bit modulus field selects a ratio from 1 to 256. The slowest setting gives fosc/8192 and the fastest gives fosc/4.

The block does not drive a second clock. It stays in the oscillator domain and provides two outputs:
- a level output with an exact 50% duty cycle;
- a one-cycle enable pulse at every level change of that output.

Transmit and receive shift logic can use the pulse as a clock enable. The level can be routed to clock pins.

Changes to the modulus or the range bit take effect only when a full bit-clock period completes, so no period is ever shortened or stretched. A hardware reset and a synchronous software reset both clear the stored settings and the counters. The software reset also holds the bit clock low while it is asserted.

Top module: `bitclk_gen`

## Requirements
- R1: With the range input low, each high phase and each low phase of `bclk` lasts 2*(M+1) clock cycles, where M is the stored modulus. One full period is therefore 4*(M+1) cycles.
- R2: With the range input high, each phase lasts 16*(M+1) cycles. One full period is therefore 32*(M+1) cycles.
- R3: The high phase and the low phase of every period are equal in length (50% duty).
- R4: `bclk_tick` is high for exactly one cycle, in the first cycle of each new `bclk` level. A tick with `bclk` high marks a rising edge, and a tick with `bclk` low marks a falling edge.
- R5: New values on `modulus` and `range_sel` are sampled only at the clock edge that ends a full period, which is the falling edge of `bclk`. A period already in progress keeps its old length.
- R6: While `rst_n` is low, `bclk` and `bclk_tick` are 0 and the stored settings are cleared to M=0 with the range bit clear. After release, the first rising tick appears 2 cycles later and the first full period is 4 cycles.
- R7: While `soft_rst` is high, `bclk` and `bclk_tick` stay 0. The stored settings and the counters are cleared. After release the block behaves as it does after R6.
- R8: The extreme settings give a period of 4 cycles (M=0, range low) and a period of 8192 cycles (M=255, range high).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_rst | input | 1 | Synchronous software reset, active high |
| range_sel | input | 1 | 1 inserts the divide-by-eight prescaler |
| modulus | input | PM_W | Modulus M; divide ratio is M+1 |
| bclk | output | 1 | Bit-clock level, 50% duty |
| bclk_tick | output | 1 | One-cycle pulse at each bclk level change |

## Verification
The divider is tried with several modulus values, both with and without the prescaler, including both ends of the range. These settings separate a wrong modulus offset from a wrong prescale factor, and they expose a period that is off by one. A setting change made just after a rising edge is compared with one made just after a falling edge; this shows whether the update waits for the end of the period or lands in the middle of it. Both resets are applied with a non-zero modulus on the input, which checks that they clear the stored setting and do not simply reload it.

// File: rtl/bitclk_gen.sv
module bitclk_gen #(
  parameter int PM_W      = 8,
  parameter int BASE_HALF = 2,
  parameter int RANGE_DIV = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_rst,
  input  logic            range_sel,
  input  logic [PM_W-1:0] modulus,
  output logic            bclk,
  output logic            bclk_tick
);

  localparam int PRE_MAX = BASE_HALF * RANGE_DIV;
  localparam int PRE_W   = (PRE_MAX > 2) ? $clog2(PRE_MAX) : 1;
  localparam logic [PRE_W-1:0] LAST_SLOW = PRE_W'(PRE_MAX - 1);
  localparam logic [PRE_W-1:0] LAST_FAST = PRE_W'(BASE_HALF - 1);

  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] pre_last;
  logic [PM_W-1:0]  mod_cnt;
  logic [PM_W-1:0]  pm_q;
  logic             rng_q;
  logic             pre_wrap;
  logic             mod_wrap;
  logic             half_done;

  assign pre_last  = rng_q ? LAST_SLOW : LAST_FAST;
  assign pre_wrap  = (pre_cnt == pre_last);
  assign mod_wrap  = (mod_cnt == pm_q);
  assign half_done = pre_wrap && mod_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt   <= '0;
      mod_cnt   <= '0;
      pm_q      <= '0;
      rng_q     <= 1'b0;
      bclk      <= 1'b0;
      bclk_tick <= 1'b0;
    end else if (soft_rst) begin
      pre_cnt   <= '0;
      mod_cnt   <= '0;
      pm_q      <= '0;
      rng_q     <= 1'b0;
      bclk      <= 1'b0;
      bclk_tick <= 1'b0;
    end else begin
      bclk_tick <= half_done;
      pre_cnt   <= pre_wrap ? '0 : pre_cnt + 1'b1;
      if (pre_wrap)
        mod_cnt <= mod_wrap ? '0 : mod_cnt + 1'b1;
      if (half_done) begin
        bclk <= ~bclk;
        if (bclk) begin
          pm_q  <= modulus;
          rng_q <= range_sel;
        end
      end
    end
  end

  AST_MOD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mod_cnt <= pm_q) else $error("modulus counter beyond limit"); // R1

  AST_PRE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pre_cnt <= pre_last) else $error("prescale counter beyond limit"); // R2

  AST_TICK_MARKS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_tick |-> (bclk != $past(bclk))) else $error("tick without level change"); // R4

  AST_LEVEL_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    !bclk_tick |-> (bclk == $past(bclk))) else $error("level change without tick"); // R4

  AST_UPDATE_AT_PERIOD_END: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    ((pm_q != $past(pm_q)) || (rng_q != $past(rng_q))) |-> (bclk_tick && !bclk))
    else $error("settings changed mid-period"); // R5

  AST_SOFT_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!bclk && !bclk_tick)) else $error("bit clock active in soft reset"); // R7

endmodule

// File: tb/bitclk_gen_tb.sv
module bitclk_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst = 1'b0;
  logic       range_sel = 1'b0;
  logic [7:0] modulus = '0;
  logic       bclk;
  logic       bclk_tick;

  int tests_run = 0;
  int tests_failed = 0;

  always #2.5 clk = ~clk;

  bitclk_gen dut_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .range_sel(range_sel), .modulus(modulus),
    .bclk(bclk), .bclk_tick(bclk_tick)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests_run++;
    if (!ok) begin
      tests_failed++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_tick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!bclk_tick);
  endtask

  task automatic wait_fall();
    int n;
    do wait_tick(n); while (bclk);
  endtask

  function automatic int half_len(input int pm, input bit rng);
    return (rng ? 16 : 2) * (pm + 1);
  endfunction

  task automatic run_cfg(input int pm, input bit rng, input string tag);
    int n1, n2, h;
    @(negedge clk);
    modulus = 8'(pm);
    range_sel = rng;
    wait_fall();
    wait_fall();
    h = half_len(pm, rng);
    wait_tick(n1);
    check(bclk == 1'b1, {tag, " rising tick level (R4)"}, int'(bclk), 1);
    wait_tick(n2);
    check(bclk == 1'b0, {tag, " falling tick level (R4)"}, int'(bclk), 0);
    check(n1 == h, {tag, " low phase length"}, n1, h);
    check(n2 == n1, {tag, " duty high==low (R3)"}, n2, n1);
  endtask

  task automatic t_hw_reset();
    int n;
    @(negedge clk);
    check(!bclk && !bclk_tick, "R6 outputs low in reset", int'(bclk) + int'(bclk_tick), 0);
    modulus = 8'd5;
    range_sel = 1'b0;
    rst_n = 1'b1;
    wait_tick(n);
    check(n == 2 && bclk, "R6 first rise 2 cycles after release", n, 2);
    wait_tick(n);
    check(n == 2 && !bclk, "R6 first fall uses cleared setting", n, 2);
    wait_tick(n);
    check(n == 12, "R6 new setting after first period", n, 12);
  endtask

  task automatic t_pulse_width();
    int n;
    modulus = 8'd3;
    range_sel = 1'b0;
    wait_fall();
    wait_fall();
    @(negedge clk);
    check(bclk_tick == 1'b0, "R4 tick lasts one cycle", int'(bclk_tick), 0);
    wait_tick(n);
    check(n == 7, "R4 next tick after one-cycle pulse", n, 7);
  endtask

  task automatic t_change_after_rise();
    int n;
    modulus = 8'd3;
    range_sel = 1'b0;
    wait_fall();
    wait_fall();
    wait_tick(n);
    modulus = 8'd1;
    wait_tick(n);
    check(n == 8, "R5 high phase keeps old length", n, 8);
    wait_tick(n);
    check(n == 4, "R5 new length after period end", n, 4);
  endtask

  task automatic t_change_after_fall();
    int n;
    modulus = 8'd3;
    range_sel = 1'b0;
    wait_fall();
    wait_fall();
    modulus = 8'd1;
    wait_tick(n);
    check(n == 8, "R5 low phase of running period unchanged", n, 8);
    wait_tick(n);
    check(n == 8, "R5 high phase of running period unchanged", n, 8);
    wait_tick(n);
    check(n == 4, "R5 following period uses new value", n, 4);
  endtask

  task automatic t_soft_reset();
    int n;
    bit held = 1'b1;
    modulus = 8'd4;
    range_sel = 1'b1;
    wait_fall();
    wait_fall();
    @(negedge clk);
    soft_rst = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      if (bclk || bclk_tick) held = 1'b0;
      @(negedge clk);
    end
    check(held, "R7 held low during soft reset", int'(held), 1);
    range_sel = 1'b0;
    soft_rst = 1'b0;
    wait_tick(n);
    check(n == 2 && bclk, "R7 first rise after soft reset", n, 2);
    wait_tick(n);
    check(n == 2, "R7 settings cleared by soft reset", n, 2);
    wait_tick(n);
    check(n == 10, "R7 input setting taken after first period", n, 10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_hw_reset();
    run_cfg(0, 1'b0, "R1 pm=0");
    run_cfg(2, 1'b0, "R1 pm=2");
    run_cfg(9, 1'b0, "R1 pm=9");
    run_cfg(0, 1'b1, "R2 pm=0");
    run_cfg(3, 1'b1, "R2 pm=3");
    t_pulse_width();
    t_change_after_rise();
    t_change_after_fall();
    t_soft_reset();
    run_cfg(0, 1'b0, "R8 fastest");
    run_cfg(255, 1'b0, "R1 pm=255");
    run_cfg(255, 1'b1, "R8 slowest");
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests_run++;
    tests_failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

endmodule